// File: doc/BRIEF.md
# Interleaved Refresh-Slot Video Byte Fetcher

This block keeps a pixel serializer supplied with bytes from video memory without ever stalling the processor that shares that memory. The video store is split by the lowest address bit into an even bank and an odd bank. Each bank is a single-port RAM with a small read queue of its own. A bank reads its next byte in any cycle where the processor is not using that bank. This covers refresh slots, in which the processor touches no memory, and cycles in which the processor is working in the other bank. Fetches are therefore opportunistic and aperiodic. The queues absorb the gaps.

The serializer takes bytes from the even queue and the odd queue in turn, so the pixel stream follows ascending byte address. It shifts out one pixel per pixel-clock enable, most significant bit first. The processor clock must run well above the byte rate, roughly sixteen to one, so that the queues keep up. A frame-start pulse rewinds both fetch addresses and empties the queues. When a needed byte is missing, the serializer emits a blank byte and raises a sticky underrun flag.

Top module: `vfetch_top`

## Requirements
- R1: A processor byte address A selects the even bank when A[0]=0 and the odd bank when A[0]=1, at word A>>1. The pixel stream carries bytes in ascending byte address, starting with the even bank after a frame start.
- R2: A bank does not fetch in a cycle where cpu_req is high, cpu_refresh is low and cpu_addr[0] names that bank.
- R3: A bank never fetches while its queue entries plus its read in flight equal FIFO_DEPTH, so no byte is dropped or skipped while the queues are full.
- R4: While the processor accesses one bank, the other bank still fetches in that same cycle whenever its queue has room.
- R5: While cpu_refresh is high, both banks fetch in the same cycle when they have room. Any processor request in that cycle is ignored: no write takes place and no read is returned.
- R6: Each bank's fetch address advances by one after every fetch and wraps from 2**BANK_AW-1 to 0.
- R7: A frame_start pulse sets both fetch addresses to 0, empties both queues, drops reads in flight, restarts the serializer on the even bank at pixel 0 and clears the underrun flag.
- R8: On each pix_ce, pix_out presents the next bit. A new byte is loaded on the 1st of every 8 enables, and its bit 7 is presented first.
- R9: If the queue due next is empty at a byte load, pix_out is 0 for that whole byte and the underrun flag is set. The serializer stays on the same bank, and the flag holds until reset or frame_start.
- R10: A processor write stores cpu_wdata at cpu_addr. A processor read drives the stored byte on cpu_rdata after the second rising edge following the request, and cpu_rdata holds it until the next read.
- R11: While rst is high, pix_out, underrun and cpu_rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor/system clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Single-cycle pulse that begins a new frame |
| pix_ce | input | 1 | Pixel clock enable; one pixel per high cycle |
| cpu_refresh | input | 1 | Processor refresh slot, no memory use |
| cpu_req | input | 1 | Processor memory access this cycle |
| cpu_we | input | 1 | Access is a write when high |
| cpu_addr | input | BANK_AW+1 | Processor byte address, bit 0 selects bank |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Registered read data |
| pix_out | output | 1 | Serial pixel output |
| underrun | output | 1 | Sticky flag: a byte was missing at load time |

## Verification
The bench builds the block with BANK_AW=4 and FIFO_DEPTH=3. The small banks mean a 40-byte run crosses the address wrap of both counters. The odd queue depth exercises pointer wrap at a non-power-of-two boundary. Long idle prefills hold both queues full for many cycles, and processor traffic that hammers one bank starves that bank alone, so a blank byte appears on its turn. Random refresh and bank-access patterns run against an image held in the bench, and a stream taken entirely during refresh slots with processor writes confirms that those writes are ignored.

// File: rtl/vfetch_pkg.sv
package vfetch_pkg;
  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/vfetch_fifo.sv
module vfetch_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic [CW-1:0]     count
);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic              do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && !flush && (count < CW'(DEPTH));
  assign do_pop  = pop && !flush && !empty;
  assign rdata   = slots[rptr];
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (do_push) slots[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/vfetch_bank.sv
module vfetch_bank #(
  parameter int BANK_AW    = 10,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int BANK_ID    = 0,
  localparam int CW        = $clog2(FIFO_DEPTH + 1),
  localparam int WORDS     = 2 ** BANK_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               cpu_refresh,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [BANK_AW:0]   cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic [CW-1:0]      q_count,
  output logic               fetch,
  output logic               room,
  output logic [BANK_AW-1:0] fetch_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               push
);
  logic [DATA_W-1:0]  mem [WORDS];
  logic               cpu_hit;
  logic [BANK_AW-1:0] ram_addr;
  logic               pend;
  logic [CW:0]        occupied;

  // processor owns this bank only outside refresh slots
  assign cpu_hit  = cpu_req && !cpu_refresh && (cpu_addr[0] == 1'(BANK_ID));
  assign occupied = {1'b0, q_count} + {{CW{1'b0}}, pend};
  assign room     = occupied < (CW+1)'(FIFO_DEPTH);
  assign fetch    = !frame_start && !cpu_hit && room;
  assign ram_addr = cpu_hit ? cpu_addr[BANK_AW:1] : fetch_addr;
  assign push     = pend;

  // single-port RAM, read-first, registered output
  always_ff @(posedge clk) begin
    if (cpu_hit && cpu_we) mem[ram_addr] <= cpu_wdata;
    rd_data <= mem[ram_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      fetch_addr <= '0;
      pend       <= 1'b0;
    end else begin
      pend <= fetch;
      if (fetch) fetch_addr <= fetch_addr + 1'b1;
    end
  end
endmodule

// File: rtl/vfetch_serializer.sv
module vfetch_serializer
  import vfetch_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              pix_ce,
  input  logic              even_empty,
  input  logic [DATA_W-1:0] even_data,
  input  logic              odd_empty,
  input  logic [DATA_W-1:0] odd_data,
  output logic              pop_even,
  output logic              pop_odd,
  output logic              pix_out,
  output logic              underrun
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  bank_e             sel;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              load;
  logic              cur_empty;
  logic [DATA_W-1:0] cur_data;

  assign load      = pix_ce && !frame_start && (bit_cnt == '0);
  assign cur_empty = (sel == BANK_ODD) ? odd_empty : even_empty;
  assign cur_data  = (sel == BANK_ODD) ? odd_data  : even_data;
  assign pop_even  = load && (sel == BANK_EVEN) && !even_empty;
  assign pop_odd   = load && (sel == BANK_ODD)  && !odd_empty;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      sel      <= BANK_EVEN;
      bit_cnt  <= '0;
      shreg    <= '0;
      pix_out  <= 1'b0;
      underrun <= 1'b0;
    end else if (pix_ce) begin
      bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      if (bit_cnt == '0) begin
        if (cur_empty) begin
          shreg    <= '0;
          pix_out  <= 1'b0;
          underrun <= 1'b1;
        end else begin
          pix_out <= cur_data[DATA_W-1];
          shreg   <= cur_data << 1;
          sel     <= (sel == BANK_EVEN) ? BANK_ODD : BANK_EVEN;
        end
      end else begin
        pix_out <= shreg[DATA_W-1];
        shreg   <= shreg << 1;
      end
    end
  end
endmodule

// File: rtl/vfetch_top.sv
module vfetch_top
  import vfetch_pkg::*;
#(
  parameter int BANK_AW    = 10,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              pix_ce,
  input  logic              cpu_refresh,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [BANK_AW:0]  cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              pix_out,
  output logic              underrun
);
  logic [NUM_BANKS-1:0]                   fetch_v, room_v, push_v, empty_v, pop_v;
  logic [NUM_BANKS-1:0][DATA_W-1:0]       rd_v, head_v;
  logic [NUM_BANKS-1:0][CW-1:0]           cnt_v;
  logic [NUM_BANKS-1:0][BANK_AW-1:0]      addr_v;
  logic                                   rd_pend;
  logic                                   rd_bank;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vfetch_bank #(
      .BANK_AW   (BANK_AW),
      .DATA_W    (DATA_W),
      .FIFO_DEPTH(FIFO_DEPTH),
      .BANK_ID   (b)
    ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .frame_start(frame_start),
      .cpu_refresh(cpu_refresh),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .q_count    (cnt_v[b]),
      .fetch      (fetch_v[b]),
      .room       (room_v[b]),
      .fetch_addr (addr_v[b]),
      .rd_data    (rd_v[b]),
      .push       (push_v[b])
    );

    vfetch_fifo #(
      .DEPTH (FIFO_DEPTH),
      .DATA_W(DATA_W)
    ) u_fifo (
      .clk  (clk),
      .rst  (rst),
      .flush(frame_start),
      .push (push_v[b]),
      .wdata(rd_v[b]),
      .pop  (pop_v[b]),
      .rdata(head_v[b]),
      .empty(empty_v[b]),
      .count(cnt_v[b])
    );
  end

  vfetch_serializer #(
    .DATA_W(DATA_W)
  ) u_ser (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .pix_ce     (pix_ce),
    .even_empty (empty_v[BANK_EVEN]),
    .even_data  (head_v[BANK_EVEN]),
    .odd_empty  (empty_v[BANK_ODD]),
    .odd_data   (head_v[BANK_ODD]),
    .pop_even   (pop_v[BANK_EVEN]),
    .pop_odd    (pop_v[BANK_ODD]),
    .pix_out    (pix_out),
    .underrun   (underrun)
  );

  // processor read return: RAM output register, then a holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      rd_bank   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      rd_pend <= cpu_req && !cpu_refresh && !cpu_we;
      rd_bank <= cpu_addr[0];
      if (rd_pend) cpu_rdata <= rd_v[rd_bank];
    end
  end
endmodule

// File: rtl/vfetch_checker.sv
module vfetch_checker #(
  parameter int BANK_AW    = 10,
  parameter int FIFO_DEPTH = 4,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   frame_start,
  input logic                   cpu_req,
  input logic                   cpu_refresh,
  input logic [BANK_AW:0]       cpu_addr,
  input logic [1:0]             fetch_v,
  input logic [1:0]             room_v,
  input logic [1:0][CW-1:0]     cnt_v,
  input logic [1:0][BANK_AW-1:0] addr_v,
  input logic                   underrun
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_v[0] <= CW'(FIFO_DEPTH)) && (cnt_v[1] <= CW'(FIFO_DEPTH))); // R3

  AST_FULL_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (cnt_v[0] == CW'(FIFO_DEPTH)) |-> !fetch_v[0]); // R3

  AST_EVEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_refresh && !cpu_addr[0]) |-> !fetch_v[0]); // R2

  AST_ODD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_refresh && cpu_addr[0]) |-> !fetch_v[1]); // R2

  AST_CROSS_FETCH: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_refresh && cpu_addr[0] && !frame_start && room_v[0]) |-> fetch_v[0]); // R4

  AST_REFRESH_BOTH: assert property (@(posedge clk) disable iff (rst)
    (cpu_refresh && !frame_start && room_v[0] && room_v[1]) |-> (fetch_v == 2'b11)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (fetch_v[1] && !frame_start) |=> (addr_v[1] == BANK_AW'($past(addr_v[1]) + 1'b1))); // R6

  AST_FRAME_RESET: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (addr_v[0] == '0 && addr_v[1] == '0 && !underrun && cnt_v == '0)); // R7

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (underrun && !frame_start) |=> underrun); // R9
endmodule

bind vfetch_top vfetch_checker #(
  .BANK_AW   (BANK_AW),
  .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (.*);

// File: tb/vfetch_top_bench.sv
module vfetch_top_bench;
  localparam int BANK_AW    = 4;
  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 3;
  localparam int NBYTES     = 2 * (2 ** BANK_AW);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frame_start = 1'b0;
  logic              pix_ce = 1'b0;
  logic              cpu_refresh = 1'b0;
  logic              cpu_req = 1'b0;
  logic              cpu_we = 1'b0;
  logic [BANK_AW:0]  cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic              pix_out;
  logic              underrun;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] img [NBYTES];
  logic [7:0] got_q [$];
  logic       first_pix;

  always #2.5 clk = ~clk;

  vfetch_top #(
    .BANK_AW   (BANK_AW),
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_vfetch_top (
    .clk, .rst, .frame_start, .pix_ce, .cpu_refresh, .cpu_req, .cpu_we,
    .cpu_addr, .cpu_wdata, .cpu_rdata, .pix_out, .underrun
  );

  function automatic logic [7:0] exp_byte(input int idx);
    return img[idx % NBYTES];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_idle();
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_refresh = 1'b0;
  endtask

  // modes: 0 idle, 1 random reads/refresh, 2 hammer even, 3 hammer odd, 4 refresh+write
  task automatic drive_cpu(input int mode);
    case (mode)
      1: begin
        cpu_refresh = ($urandom % 4) == 0;
        cpu_req     = $urandom % 2;
        cpu_we      = 1'b0;
        cpu_addr    = ($urandom % NBYTES);
      end
      2: begin cpu_refresh = 0; cpu_req = 1; cpu_we = 0; cpu_addr = 6; end
      3: begin cpu_refresh = 0; cpu_req = 1; cpu_we = 0; cpu_addr = 7; end
      4: begin
        cpu_refresh = 1; cpu_req = 1; cpu_we = 1; cpu_addr = 5;
        cpu_wdata = ~img[5];
      end
      default: cpu_idle();
    endcase
  endtask

  task automatic cpu_write(input int a, input logic [7:0] d);
    @(negedge clk);
    cpu_refresh = 0; cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_idle();
  endtask

  task automatic cpu_read(input int a, output logic [7:0] d);
    @(negedge clk);
    cpu_refresh = 0; cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    cpu_idle();
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic frame_pulse(input int mode);
    @(negedge clk);
    frame_start = 1; drive_cpu(mode);
    @(negedge clk);
    frame_start = 0; drive_cpu(mode);
  endtask

  task automatic stream(input int nbytes, input int prefill, input int mode);
    int bits = 0;
    int cyc = 0;
    logic [7:0] acc = '0;
    logic prev_ce = 1'b0;
    got_q.delete();
    forever begin
      @(negedge clk);
      if (prev_ce) begin
        if (bits == 0) first_pix = pix_out;
        acc = {acc[6:0], pix_out};
        bits++;
        if (bits % 8 == 0) got_q.push_back(acc);
      end
      if (bits >= nbytes * 8) break;
      drive_cpu(mode);
      pix_ce  = (cyc >= prefill) && (((cyc - prefill) % 2) == 0);
      prev_ce = pix_ce;
      cyc++;
    end
    pix_ce = 0;
    cpu_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL R0 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NBYTES; i++) img[i] = $urandom;
    img[0] = 8'h80;
    img[1] = 8'h01;

    repeat (3) @(negedge clk);
    check("R11 pix_out in reset", pix_out, 0);
    check("R11 underrun in reset", underrun, 0);
    check("R11 cpu_rdata in reset", cpu_rdata, 0);
    rst = 0;

    for (int i = 0; i < NBYTES; i++) cpu_write(i, img[i]);
    cpu_read(0, rd);  check("R10 readback addr 0", rd, img[0]);
    cpu_read(1, rd);  check("R10 R1 readback addr 1", rd, img[1]);
    cpu_read(17, rd); check("R10 readback addr 17", rd, img[17]);
    cpu_read(30, rd); check("R10 readback addr 30", rd, img[30]);

    // long full prefill, random traffic, wrap of both banks
    frame_pulse(0);
    stream(NBYTES + 8, 80, 1);
    check("R8 first pixel is bit 7", first_pix, 1);
    for (int i = 0; i < NBYTES + 8; i++)
      check($sformatf("R1 R3 R6 R8 byte %0d", i), got_q[i], exp_byte(i));
    check("R3 no underrun with full queues", underrun, 0);

    // refresh slots only, processor writes must be ignored
    frame_pulse(4);
    stream(6, 10, 4);
    for (int i = 0; i < 6; i++)
      check($sformatf("R5 R7 refresh byte %0d", i), got_q[i], exp_byte(i));
    check("R5 no underrun under refresh", underrun, 0);
    cpu_read(5, rd);
    check("R5 write during refresh ignored", rd, img[5]);

    // processor hammers odd bank: even still fills, odd starves
    frame_pulse(3);
    stream(3, 20, 3);
    check("R4 even byte fetched during odd access", got_q[0], img[0]);
    check("R9 R2 odd starved byte blank", got_q[1], 0);
    check("R9 stays on odd bank, still blank", got_q[2], 0);
    check("R9 underrun set", underrun, 1);
    repeat (5) @(negedge clk);
    check("R9 underrun sticky", underrun, 1);

    frame_pulse(0);
    @(negedge clk);
    check("R7 frame_start clears underrun", underrun, 0);

    // processor hammers even bank: first byte blank
    frame_pulse(2);
    stream(1, 20, 2);
    check("R2 R9 even starved byte blank", got_q[0], 0);
    check("R2 R9 underrun after even starve", underrun, 1);

    // recovery after frame start
    frame_pulse(0);
    stream(4, 12, 0);
    for (int i = 0; i < 4; i++)
      check($sformatf("R7 restart byte %0d", i), got_q[i], exp_byte(i));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule